// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a ten-input successive-approximation converter. A conversion starts from a software write or, when armed, from an external trigger pulse. The controller first waits a programmable number of cycles. It then steers the analog multiplexer to a single input or to an adjacent input pair, and selects the positive and negative reference sources. After one sampling cycle it resolves a sign and twelve magnitude bits against a comparator, one bit per cycle. The result is a signed value. The controller raises a done flag, and optionally an interrupt, and then stops until the next start.

Software sees four word registers: control, delay, result and status. The analog parts stay outside the block: the comparator, the trial-code DAC and the multiplexer. The block drives them through dedicated select and code outputs and reads back a single comparator bit.

Top module: `sar_conv_ctrl`

## Requirements
- R1: In single-ended mode (control bit 1 = 0), the 4-bit select field (control bits 5:2) accepts values 0 to 9. That value appears on `mux_pos_o`, `mux_diff_o` stays 0, and the result is the non-negative magnitude, clipped at 4095.
- R2: In differential mode (control bit 1 = 1), the low 3 bits of the select field give a pair index k from 0 to 4. `mux_pos_o` = 2k, `mux_neg_o` = 2k+1 and `mux_diff_o` = 1. The sign comes from the first comparator decision: comparator 1 against code 0 means positive.
- R3: A start is refused and nothing is sampled in three cases: a single-ended select above 9, a pair index above 4, or a negative reference code of 3. Status bit 3 (reject) is then set and stays set until the next accepted start.
- R4: With delay register value D (address 1), `sample_o` is high for exactly one cycle. That cycle comes D+1 clock edges after the edge that accepts the start.
- R5: A conversion runs once. When it ends, busy (status bit 1) is 0, and `sample_o` stays low until another start is accepted.
- R6: A one-cycle pulse on `ext_trig_i` starts a conversion only when control bit 11 is set. Otherwise the pulse has no effect. A control write with bit 0 set starts a conversion at once, using the newly written fields.
- R7: A start from software or from the trigger while busy (delay, sampling or approximation) is ignored, and sticky status bit 2 (overrun) is set. Writing address 3 with bit 2 set clears it.
- R8: The positive reference code (control bits 7:6: 0 internal supply, 1 reference pin, 2 input 0, 3 input 1) and the negative reference code (bits 9:8: 0 internal supply, 1 input 2, 2 input 3) are latched at the accepting edge and appear on `ref_pos_o` and `ref_neg_o`. They stay unchanged, together with the mux selects, while busy.
- R9: Approximation runs most significant bit first, one bit per cycle. The done flag rises RES+2 cycles after the cycle in which `sample_o` is high. `dac_code_o` is 0 while idle.
- R10: The done flag (status bit 0) is cleared by a read of the result register or by an accepted start. `irq_o` is high exactly while done is set and control bit 10 is set.
- R11: A read of address 2 returns the signed result as 13-bit two's complement, sign-extended to 16 bits. A negative result has a magnitude of at most 4095.
- R12: After reset, status, result, all selects, `sample_o`, `dac_code_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 2 | 0 control, 1 delay, 2 result, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| ext_trig_i | input | 1 | Synchronous external start pulse |
| comp_i | input | 1 | Comparator decision: input magnitude at least trial code |
| sample_o | output | 1 | High during the single sampling cycle |
| dac_code_o | output | 12 | Trial code for the DAC |
| dac_neg_o | output | 1 | Trial polarity: 1 compares against a negative level |
| mux_diff_o | output | 1 | Differential pair selected |
| mux_pos_o | output | 4 | Positive (or only) input select |
| mux_neg_o | output | 4 | Negative input select in differential mode |
| ref_pos_o | output | 2 | Positive reference select |
| ref_neg_o | output | 2 | Negative reference select |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions check on every cycle the properties that hold at all times. They cover the legal range of the selects while busy, the pairing of the differential inputs, the stability of the selects and references during a conversion, and a fixed distance from the sampling cycle to done. They also check that busy is low when done rises, that the interrupt never appears without done, and that the trial code is idle outside conversions. Other behaviours need the bench's scenarios: the numeric value of a converted result, including clipping and negative pairs, and the exact start delay. The same holds for triggers that are disarmed or arrive while busy, overrun clearing, refused configurations, and done being cleared by a read or a new start.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAMPLE,
    ST_SIGN,
    ST_BITS
  } seq_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DLY  = 2'd1;
  localparam logic [1:0] ADDR_RES  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int GO_BIT   = 0;
  localparam int DIFF_BIT = 1;
  localparam int SEL_LSB  = 2;

  localparam int STAT_DONE = 0;
  localparam int STAT_BUSY = 1;
  localparam int STAT_OVR  = 2;
  localparam int STAT_REJ  = 3;

endpackage

// File: rtl/sar_chan_decode.sv
module sar_chan_decode #(
  parameter int NCH    = 10,
  parameter int NPAIR  = 5,
  parameter int CH_W   = 4,
  parameter int PAIR_W = 3
) (
  input  logic            diff,
  input  logic [CH_W-1:0] sel,
  input  logic [1:0]      refn,
  output logic            legal,
  output logic [CH_W-1:0] pos,
  output logic [CH_W-1:0] neg
);

  localparam logic [CH_W-1:0]   CH_MAX   = CH_W'(NCH - 1);
  localparam logic [PAIR_W-1:0] PAIR_MAX = PAIR_W'(NPAIR - 1);

  logic [PAIR_W-1:0] pair;
  logic [CH_W-1:0]   pair_pos;

  assign pair     = sel[PAIR_W-1:0];
  assign pair_pos = CH_W'({pair, 1'b0});

  always_comb begin
    legal = (refn != 2'd3) && (diff ? (pair <= PAIR_MAX) : (sel <= CH_MAX));
    pos   = diff ? pair_pos : sel;
    neg   = diff ? (pair_pos + CH_W'(1)) : '0;
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_conv_pkg::*;
#(
  parameter int RES   = 12,
  parameter int DLY_W = 8,
  parameter int CH_W  = 4,
  parameter int BIT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [DLY_W-1:0] delay,
  input  logic            diff_in,
  input  logic [CH_W-1:0] pos_in,
  input  logic [CH_W-1:0] neg_in,
  input  logic [1:0]      rp_in,
  input  logic [1:0]      rn_in,
  input  logic            comp,
  output logic            busy,
  output logic            fin,
  output logic [RES:0]    res_out,
  output logic            sample,
  output logic [RES-1:0]  dac_code,
  output logic            dac_neg,
  output logic            mux_diff,
  output logic [CH_W-1:0] mux_pos,
  output logic [CH_W-1:0] mux_neg,
  output logic [1:0]      ref_pos,
  output logic [1:0]      ref_neg
);

  seq_state_t       state_q;
  logic [DLY_W-1:0] dly_q;
  logic [BIT_W-1:0] bit_q;
  logic [RES-1:0]   mag_q;
  logic             sign_q;

  logic [RES-1:0] trial;
  logic [RES-1:0] mag_fin;
  logic [RES:0]   mag_ext;

  assign trial   = RES'(1) << bit_q;
  assign mag_fin = comp ? (mag_q | trial) : mag_q;
  assign mag_ext = {1'b0, mag_fin};

  always_comb begin
    busy     = (state_q != ST_IDLE);
    sample   = (state_q == ST_SAMPLE);
    fin      = (state_q == ST_BITS) && (bit_q == '0);
    res_out  = sign_q ? (~mag_ext + (RES+1)'(1)) : mag_ext;
    dac_code = (state_q == ST_BITS) ? (mag_q | trial) : '0;
    dac_neg  = (state_q == ST_BITS) && sign_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      dly_q    <= '0;
      bit_q    <= '0;
      mag_q    <= '0;
      sign_q   <= 1'b0;
      mux_diff <= 1'b0;
      mux_pos  <= '0;
      mux_neg  <= '0;
      ref_pos  <= '0;
      ref_neg  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_WAIT;
            dly_q    <= delay;
            mux_diff <= diff_in;
            mux_pos  <= pos_in;
            mux_neg  <= neg_in;
            ref_pos  <= rp_in;
            ref_neg  <= rn_in;
          end
        end
        ST_WAIT: begin
          if (dly_q == '0) state_q <= ST_SAMPLE;
          else             dly_q   <= dly_q - DLY_W'(1);
        end
        ST_SAMPLE: begin
          state_q <= ST_SIGN;
          mag_q   <= '0;
        end
        ST_SIGN: begin
          sign_q  <= mux_diff & ~comp;
          bit_q   <= BIT_W'(RES - 1);
          state_q <= ST_BITS;
        end
        ST_BITS: begin
          mag_q <= mag_fin;
          if (bit_q == '0) state_q <= ST_IDLE;
          else             bit_q   <= bit_q - BIT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_conv_pkg::*;
#(
  parameter int RES   = 12,
  parameter int DLY_W = 8,
  parameter int DW    = 16,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             ext_trig,
  input  logic             busy,
  input  logic             fin,
  input  logic [RES:0]     res_in,
  input  logic             legal,
  output logic             accept,
  output logic             done,
  output logic             nx_diff,
  output logic [CH_W-1:0]  nx_sel,
  output logic [1:0]       nx_refp,
  output logic [1:0]       nx_refn,
  output logic [DLY_W-1:0] delay,
  output logic             irq
);

  localparam int RP_LSB  = SEL_LSB + CH_W;
  localparam int RN_LSB  = RP_LSB + 2;
  localparam int IRQ_BIT = RN_LSB + 2;
  localparam int EXT_BIT = IRQ_BIT + 1;

  logic            diff_q, irqen_q, exten_q;
  logic [CH_W-1:0] sel_q;
  logic [1:0]      rp_q, rn_q;
  logic            ovr_q, rej_q;
  logic [RES:0]    res_q;
  logic            nx_irqen;
  logic            wr_ctrl, soft_go, start_req, done_d;
  logic [DW-1:0]   ctrl_view, stat_view, res_view, rd_mux;

  assign wr_ctrl   = wr && (addr == ADDR_CTRL);
  assign soft_go   = wr_ctrl && wdata[GO_BIT];
  assign start_req = soft_go || (ext_trig && exten_q);
  assign accept    = start_req && !busy && legal;

  always_comb begin
    nx_diff  = wr_ctrl ? wdata[DIFF_BIT]           : diff_q;
    nx_sel   = wr_ctrl ? wdata[SEL_LSB +: CH_W]    : sel_q;
    nx_refp  = wr_ctrl ? wdata[RP_LSB +: 2]        : rp_q;
    nx_refn  = wr_ctrl ? wdata[RN_LSB +: 2]        : rn_q;
    nx_irqen = wr_ctrl ? wdata[IRQ_BIT]            : irqen_q;
  end

  always_comb begin
    done_d = done;
    if (rd && (addr == ADDR_RES)) done_d = 1'b0;
    if (accept)                   done_d = 1'b0;
    if (fin)                      done_d = 1'b1;
  end

  always_comb begin
    ctrl_view                   = '0;
    ctrl_view[DIFF_BIT]         = diff_q;
    ctrl_view[SEL_LSB +: CH_W]  = sel_q;
    ctrl_view[RP_LSB +: 2]      = rp_q;
    ctrl_view[RN_LSB +: 2]      = rn_q;
    ctrl_view[IRQ_BIT]          = irqen_q;
    ctrl_view[EXT_BIT]          = exten_q;
    stat_view                   = '0;
    stat_view[STAT_DONE]        = done;
    stat_view[STAT_BUSY]        = busy;
    stat_view[STAT_OVR]         = ovr_q;
    stat_view[STAT_REJ]         = rej_q;
    res_view = {{(DW-RES-1){res_q[RES]}}, res_q};
    unique case (addr)
      ADDR_CTRL: rd_mux = ctrl_view;
      ADDR_DLY:  rd_mux = DW'(delay);
      ADDR_RES:  rd_mux = res_view;
      default:   rd_mux = stat_view;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q  <= 1'b0;
      sel_q   <= '0;
      rp_q    <= '0;
      rn_q    <= '0;
      irqen_q <= 1'b0;
      exten_q <= 1'b0;
      delay   <= '0;
      done    <= 1'b0;
      irq     <= 1'b0;
      ovr_q   <= 1'b0;
      rej_q   <= 1'b0;
      res_q   <= '0;
      rdata   <= '0;
    end else begin
      if (wr_ctrl) begin
        diff_q  <= nx_diff;
        sel_q   <= nx_sel;
        rp_q    <= nx_refp;
        rn_q    <= nx_refn;
        irqen_q <= nx_irqen;
        exten_q <= wdata[EXT_BIT];
      end
      if (wr && (addr == ADDR_DLY)) delay <= wdata[DLY_W-1:0];
      done <= done_d;
      irq  <= done_d && nx_irqen;
      if (start_req && busy)
        ovr_q <= 1'b1;
      else if (wr && (addr == ADDR_STAT) && wdata[STAT_OVR])
        ovr_q <= 1'b0;
      if (start_req && !busy && !legal) rej_q <= 1'b1;
      else if (accept)                  rej_q <= 1'b0;
      if (fin) res_q <= res_in;
      if (rd)  rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int NCH   = 10,
  parameter int NPAIR = 5,
  parameter int RES   = 12,
  parameter int DLY_W = 8,
  parameter int DW    = 16,
  localparam int CH_W   = $clog2(NCH),
  localparam int PAIR_W = $clog2(NPAIR),
  localparam int BIT_W  = $clog2(RES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ext_trig_i,
  input  logic            comp_i,
  output logic            sample_o,
  output logic [RES-1:0]  dac_code_o,
  output logic            dac_neg_o,
  output logic            mux_diff_o,
  output logic [CH_W-1:0] mux_pos_o,
  output logic [CH_W-1:0] mux_neg_o,
  output logic [1:0]      ref_pos_o,
  output logic [1:0]      ref_neg_o,
  output logic            irq_o
);

  logic             seq_busy, seq_fin, accept, done_flag, legal;
  logic [RES:0]     seq_res;
  logic             nx_diff;
  logic [CH_W-1:0]  nx_sel, dec_pos, dec_neg;
  logic [1:0]       nx_refp, nx_refn;
  logic [DLY_W-1:0] delay;

  sar_regs #(.RES(RES), .DLY_W(DLY_W), .DW(DW), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ext_trig(ext_trig_i),
    .busy(seq_busy), .fin(seq_fin), .res_in(seq_res), .legal(legal),
    .accept(accept), .done(done_flag), .nx_diff(nx_diff), .nx_sel(nx_sel),
    .nx_refp(nx_refp), .nx_refn(nx_refn), .delay(delay), .irq(irq_o)
  );

  sar_chan_decode #(.NCH(NCH), .NPAIR(NPAIR), .CH_W(CH_W), .PAIR_W(PAIR_W)) u_dec (
    .diff(nx_diff), .sel(nx_sel), .refn(nx_refn),
    .legal(legal), .pos(dec_pos), .neg(dec_neg)
  );

  sar_seq #(.RES(RES), .DLY_W(DLY_W), .CH_W(CH_W), .BIT_W(BIT_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .delay(delay),
    .diff_in(nx_diff), .pos_in(dec_pos), .neg_in(dec_neg),
    .rp_in(nx_refp), .rn_in(nx_refn), .comp(comp_i),
    .busy(seq_busy), .fin(seq_fin), .res_out(seq_res), .sample(sample_o),
    .dac_code(dac_code_o), .dac_neg(dac_neg_o), .mux_diff(mux_diff_o),
    .mux_pos(mux_pos_o), .mux_neg(mux_neg_o),
    .ref_pos(ref_pos_o), .ref_neg(ref_neg_o)
  );

endmodule

// File: rtl/sar_conv_checker.sv
module sar_conv_checker #(
  parameter int NCH  = 10,
  parameter int RES  = 12,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            sample,
  input logic            busy,
  input logic            done,
  input logic            irq,
  input logic [RES-1:0]  dac_code,
  input logic            mux_diff,
  input logic [CH_W-1:0] mux_pos,
  input logic [CH_W-1:0] mux_neg,
  input logic [1:0]      ref_pos,
  input logic [1:0]      ref_neg
);

  logic [7:0] since_sample;

  always_ff @(posedge clk) begin
    if (rst)                     since_sample <= 8'hFF;
    else if (sample)             since_sample <= 8'd0;
    else if (since_sample != 8'hFF) since_sample <= since_sample + 8'd1;
  end

  assert_sar_length_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (since_sample == 8'(RES + 1)));

  assert_dac_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_code == '0));

  assert_one_shot_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);

  assert_single_range_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && !mux_diff) |-> (mux_pos <= CH_W'(NCH - 1)));

  assert_pair_adjacent_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && mux_diff) |-> ((mux_neg == mux_pos + CH_W'(1)) && !mux_pos[0]));

  assert_neg_ref_legal_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ref_neg != 2'd3));

  assert_select_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      ($stable(mux_pos) && $stable(mux_neg) && $stable(mux_diff) &&
       $stable(ref_pos) && $stable(ref_neg)));

  assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

endmodule

bind sar_conv_ctrl sar_conv_checker #(.NCH(NCH), .RES(RES), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .sample(sample_o), .busy(seq_busy), .done(done_flag),
  .irq(irq_o), .dac_code(dac_code_o), .mux_diff(mux_diff_o),
  .mux_pos(mux_pos_o), .mux_neg(mux_neg_o),
  .ref_pos(ref_pos_o), .ref_neg(ref_neg_o)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

  localparam int RES = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_trig_i = 1'b0;
  logic        comp_i;
  logic        sample_o, dac_neg_o, mux_diff_o, irq_o;
  logic [11:0] dac_code_o;
  logic [3:0]  mux_pos_o, mux_neg_o;
  logic [1:0]  ref_pos_o, ref_neg_o;

  int n_chk = 0, n_fail = 0, n_samp = 0;
  int vin = 0;

  always #4 clk = ~clk;

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig_i(ext_trig_i),
    .comp_i(comp_i), .sample_o(sample_o), .dac_code_o(dac_code_o),
    .dac_neg_o(dac_neg_o), .mux_diff_o(mux_diff_o), .mux_pos_o(mux_pos_o),
    .mux_neg_o(mux_neg_o), .ref_pos_o(ref_pos_o), .ref_neg_o(ref_neg_o),
    .irq_o(irq_o)
  );

  // comparator model: magnitude of the input against the trial level
  always_comb begin
    if (dac_neg_o) comp_i = (-vin >= int'(dac_code_o));
    else           comp_i = (vin >= int'(dac_code_o));
  end

  always @(negedge clk) if (!rst && sample_o) n_samp++;

  // {diff, sel[3:0], refp[1:0], refn[1:0], delay[7:0], vin[15:0]}
  localparam logic [32:0] VECS [0:7] = '{
    {1'b0, 4'd0, 2'd0, 2'd0, 8'd0,  16'd0},
    {1'b0, 4'd9, 2'd1, 2'd1, 8'd3,  16'd4095},
    {1'b0, 4'd5, 2'd2, 2'd2, 8'd1,  16'd1234},
    {1'b0, 4'd3, 2'd3, 2'd0, 8'd10, 16'd5000},
    {1'b1, 4'd0, 2'd0, 2'd1, 8'd2,  16'hFFFF},
    {1'b1, 4'd4, 2'd1, 2'd2, 8'd0,  16'hF001},
    {1'b1, 4'd2, 2'd2, 2'd0, 8'd5,  16'd2730},
    {1'b1, 4'd3, 2'd3, 2'd1, 8'd7,  16'hE890}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(input bit diff, input logic [3:0] sel,
      input logic [1:0] rp, input logic [1:0] rn, input bit ien, input bit een, input bit go);
    return {4'b0, een, ien, rn, rp, sel, diff, go};
  endfunction

  function automatic int exp_res(input bit diff, input int v);
    int m = (v < 0) ? -v : v;
    if (m > 4095) m = 4095;
    if (!diff) return (v < 0) ? 0 : m;
    return (v < 0) ? -m : m;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse_trig();
    @(negedge clk); ext_trig_i = 1'b1;
    @(negedge clk); ext_trig_i = 1'b0;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq_o && k < 1000) begin @(negedge clk); k++; end
  endtask

  task automatic run_vec(input logic [32:0] v);
    logic [15:0] d;
    int k, e, p;
    bit df = v[32];
    vin = int'($signed(v[15:0]));
    reg_write(2'd1, {8'd0, v[23:16]});
    reg_write(2'd0, ctrl(df, v[31:28], v[27:26], v[25:24], 1'b1, 1'b0, 1'b1));
    k = 0;
    while (!sample_o && k < 1000) begin @(negedge clk); k++; end
    chk(k == int'(v[23:16]) + 1, "R4 start delay", k, int'(v[23:16]) + 1);
    p = df ? 2 * int'(v[30:28]) : int'(v[31:28]);
    chk(mux_diff_o == df, df ? "R2 diff flag" : "R1 diff flag", mux_diff_o, df);
    chk(int'(mux_pos_o) == p, df ? "R2 pos select" : "R1 pos select", mux_pos_o, p);
    if (df) chk(int'(mux_neg_o) == p + 1, "R2 neg select", mux_neg_o, p + 1);
    chk({ref_pos_o, ref_neg_o} == v[27:24], "R8 reference select",
        {ref_pos_o, ref_neg_o}, v[27:24]);
    wait_irq(k);
    chk(k == RES + 2, "R9 sample to done", k, RES + 2);
    reg_read(2'd3, d);
    chk(d == 16'd1, "R5 status after conversion", d, 1);
    reg_read(2'd2, d);
    e = exp_res(df, vin);
    chk(int'($signed(d)) == e, df ? "R11 R2 signed result" : "R11 R1 result",
        int'($signed(d)), e);
    chk(irq_o == 1'b0, "R10 irq after result read", irq_o, 0);
  endtask

  initial begin
    repeat (2000000 / 8) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int k, s0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk(sample_o == 1'b0 && irq_o == 1'b0 && dac_code_o == '0, "R12 outputs idle",
        {sample_o, irq_o, dac_code_o}, 0);
    chk({mux_pos_o, mux_neg_o, ref_pos_o, ref_neg_o, mux_diff_o} == '0,
        "R12 selects zero", {mux_pos_o, mux_neg_o}, 0);
    reg_read(2'd3, d);
    chk(d == 16'd0, "R12 status", d, 0);
    reg_read(2'd2, d);
    chk(d == 16'd0, "R12 result", d, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R3 refused configurations
    s0 = n_samp;
    reg_write(2'd0, ctrl(1'b0, 4'd10, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1));
    reg_read(2'd3, d);
    chk(d == 16'd8, "R3 single select 10 refused", d, 8);
    reg_write(2'd0, ctrl(1'b1, 4'd5, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1));
    reg_read(2'd3, d);
    chk(d == 16'd8, "R3 pair 5 refused", d, 8);
    reg_write(2'd0, ctrl(1'b0, 4'd2, 2'd0, 2'd3, 1'b1, 1'b0, 1'b1));
    reg_read(2'd3, d);
    chk(d == 16'd8, "R3 neg reference 3 refused", d, 8);
    repeat (5) @(negedge clk);
    chk(n_samp == s0, "R3 nothing sampled", n_samp - s0, 0);

    // R6 disarmed trigger has no effect, armed trigger starts
    vin = 700;
    reg_write(2'd1, 16'd60);
    reg_write(2'd0, ctrl(1'b0, 4'd1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0));
    pulse_trig();
    repeat (10) @(negedge clk);
    reg_read(2'd3, d);
    chk(d == 16'd8, "R6 disarmed trigger ignored", d, 8);
    reg_write(2'd0, ctrl(1'b0, 4'd1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0));
    pulse_trig();
    reg_read(2'd3, d);
    chk(d == 16'd2, "R6 armed trigger starts, R3 reject cleared", d, 2);

    // R7 start during delay ignored, overrun sticky
    pulse_trig();
    reg_write(2'd0, ctrl(1'b1, 4'd4, 2'd3, 2'd2, 1'b1, 1'b1, 1'b1));
    reg_read(2'd3, d);
    chk(d == 16'd6, "R7 overrun while busy", d, 6);
    chk(mux_pos_o == 4'd1 && mux_diff_o == 1'b0, "R7 R8 busy selects unchanged",
        mux_pos_o, 1);
    wait_irq(k);
    reg_read(2'd3, d);
    chk(d == 16'd5, "R7 overrun kept after done", d, 5);
    reg_write(2'd3, 16'h0004);
    reg_read(2'd3, d);
    chk(d == 16'd1, "R7 overrun cleared", d, 1);
    reg_read(2'd2, d);
    chk(int'($signed(d)) == 700, "R7 first conversion result kept", int'($signed(d)), 700);

    // R10 done cleared by a new start; irq gated by enable
    reg_write(2'd1, 16'd0);
    reg_write(2'd0, ctrl(1'b0, 4'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1));
    wait_irq(k);
    reg_write(2'd1, 16'd40);
    reg_write(2'd0, ctrl(1'b0, 4'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1));
    reg_read(2'd3, d);
    chk(d == 16'd2, "R10 start clears done", d, 2);
    k = 0;
    d = 16'd0;
    while (!d[0] && k < 200) begin reg_read(2'd3, d); k++; end
    chk(d == 16'd1, "R10 done without irq enable", d, 1);
    chk(irq_o == 1'b0, "R10 irq masked", irq_o, 0);

    // R5 stays stopped
    s0 = n_samp;
    repeat (40) @(negedge clk);
    chk(n_samp == s0, "R5 no further sampling", n_samp - s0, 0);
    reg_read(2'd3, d);
    chk(d == 16'd1, "R5 idle with done", d, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule